// File: doc/BRIEF.md
# Programmable-Modulus Lock-Free LFSR Divider

This block is a small synchronous divider. It counts with a 4-stage or 5-stage linear feedback shift register instead of a binary sequence. The basic feedback is the inverted parity of two taps. Two AND-decoded terms are ORed together and XORed into that feedback. The first term detects a run of ones in the low stages, so the all-ones state can never trap the counter. The second term matches one chosen state and flips the feedback there. Flipping the feedback makes the register jump to another state of its sequence, which shortens the loop to any length the `MODULUS` parameter asks for.

The user sets only `WIDTH` and `MODULUS`. The decode state, and the choice of whether the top stage joins the low-stage AND term, are worked out during elaboration. This is done by stepping the feedback function until a loop of the requested length is found. A configuration that is out of range, or that no setting can reach, stops elaboration with an error.

Reset loads all zeros. While `enable` is high, the register advances once per clock. `wrap` marks one point of the loop: the decoded state, or the all-zeros state when no decode is needed. It is high for exactly one enabled cycle per pass through the loop. If the shortened loop does not contain the all-zeros state, the counter first runs a short entry path from reset before the first `wrap`.

Top module: `lfsr_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes all zeros after that edge, and `wrap` stays low while `rst` is high.
- R2: A clock edge with `enable` low leaves `count` unchanged, and `wrap` is low for that cycle.
- R3: Each enabled edge shifts the stages one place toward the top (bit i+1 takes bit i, where bit 0 is stage 1), and stage 1 (bit 0) takes the feedback.
- R4: After reset, the first `wrap` comes within 2^WIDTH enabled edges. After that, `wrap` recurs every `MODULUS` enabled edges. This holds for every supported modulus: 5 to 16 for WIDTH 4, and 2 to 32 for WIDTH 5.
- R5: No value of `count` repeats between one `wrap` and the next.
- R6: `wrap` is high in the enabled cycles that start each loop pass and in no other cycle, so it never lasts two cycles.
- R7: With `MODULUS` equal to 2^WIDTH, every one of the 2^WIDTH values, all-ones included, appears once per loop, and the counter leaves the all-ones state normally.
- R8: With `MODULUS` equal to 2^WIDTH−1, the all-ones value never appears.
- R9: Idle cycles (with `enable` low) inserted anywhere leave the sequence unchanged: the value after k enabled edges is the same as when counting without idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads all zeros |
| enable | input | 1 | Advance the register on this edge |
| count | output | WIDTH | Current register value, bit 0 is stage 1 |
| wrap | output | 1 | One-cycle marker of the loop point |

## Verification
The bench builds twelve 4-stage instances, one for each modulus from 5 to 16, and thirty-one 5-stage instances, one for each modulus from 2 to 32. All of them share the same stimulus. This covers every decode configuration the elaboration search can pick: plain full length, the all-ones skip, forward jumps that keep the reset state in the loop, and backward jumps that leave an entry path. Loop length, value uniqueness, wrap placement and the shift relation are measured for each instance against its modulus alone. A second pass with irregular idle cycles is compared against the free-running record.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advance;
    logic feedBit;
  } divStrobe_t;

  // One step of the modified feedback, used only at elaboration time
  function automatic logic [4:0] stepModel(input int width, input logic topInAnd,
                                           input logic useDecode, input logic [4:0] decodeState,
                                           input logic [4:0] s);
    logic base;
    logic lowOnes;
    logic fb;
    logic [4:0] mask;
    if (width == 4) begin
      base    = ~(s[2] ^ s[3]);
      lowOnes = (&s[2:0]) & (topInAnd ? s[3] : 1'b1);
      mask    = 5'h0F;
    end else begin
      base    = ~(s[2] ^ s[4]);
      lowOnes = (&s[3:0]) & (topInAnd ? s[4] : 1'b1);
      mask    = 5'h1F;
    end
    fb = base ^ (lowOnes | (useDecode && (s == decodeState)));
    return {s[3:0], fb} & mask;
  endfunction

  // Loop length seen from reset, measured between two visits of the marker state
  function automatic int loopLength(input int width, input logic topInAnd,
                                    input logic useDecode, input logic [4:0] decodeState);
    logic [4:0] s;
    logic [4:0] marker;
    int firstSeen;
    s         = 5'd0;
    marker    = useDecode ? decodeState : 5'd0;
    firstSeen = -1;
    for (int k = 0; k < 80; k++) begin
      if (s == marker) begin
        if (firstSeen < 0) firstSeen = k;
        else return k - firstSeen;
      end
      s = stepModel(width, topInAnd, useDecode, decodeState, s);
    end
    return 0;
  endfunction

  // Result bits: [7] found, [6] use decode, [5] top stage in AND term, [4:0] decode state
  function automatic logic [7:0] chooseConfig(input int width, input int modulus);
    for (int f = 0; f < 2; f++)
      if (loopLength(width, f[0], 1'b0, 5'd0) == modulus)
        return {1'b1, 1'b0, f[0], 5'd0};
    for (int p = 0; p < (1 << width); p++)
      for (int f = 0; f < 2; f++)
        if (loopLength(width, f[0], 1'b1, p[4:0]) == modulus)
          return {1'b1, 1'b1, f[0], p[4:0]};
    return 8'd0;
  endfunction

endpackage

// File: rtl/lfsr_div_path.sv
module lfsr_div_path
  import lfsr_div_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  divStrobe_t       strobes,
  output logic [WIDTH-1:0] state
);

  always_ff @(posedge clk) begin
    if (strobes.clear)        state <= '0;
    else if (strobes.advance) state <= {state[WIDTH-2:0], strobes.feedBit};
  end

  // R1: a clear edge leaves the register at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    strobes.clear |=> state == '0);

  // R2: no advance strobe, no change
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.advance |=> $stable(state));

  // R3: stages move one place toward the top
  p_shift_up_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.advance |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));

endmodule

// File: rtl/lfsr_div_ctrl.sv
module lfsr_div_ctrl
  import lfsr_div_pkg::*;
#(
  parameter int               WIDTH        = 4,
  parameter int               MODULUS      = 16,
  parameter bit               TOP_IN_AND   = 1'b0,
  parameter bit               USE_DECODE   = 1'b0,
  parameter logic [WIDTH-1:0] DECODE_STATE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] state,
  output divStrobe_t       strobes,
  output logic             wrap
);

  localparam logic [WIDTH-1:0] MARK_STATE = USE_DECODE ? DECODE_STATE : '0;
  localparam int               CW         = $clog2((2 ** WIDTH) + 2) + 1;

  logic baseFb;
  logic topTerm;
  logic lowOnes;
  logic decodeHit;
  logic atMark;

  generate
    if (WIDTH == 4) begin : g_taps4
      assign baseFb = ~(state[2] ^ state[3]);
    end else begin : g_taps5
      assign baseFb = ~(state[2] ^ state[4]);
    end
  endgenerate

  assign topTerm   = TOP_IN_AND ? state[WIDTH-1] : 1'b1;
  assign lowOnes   = (&state[WIDTH-2:0]) & topTerm;
  assign decodeHit = USE_DECODE && (state == DECODE_STATE);
  assign atMark    = (state == MARK_STATE);

  always_comb begin
    strobes.clear   = rst;
    strobes.advance = enable && !rst;
    strobes.feedBit = baseFb ^ (lowOnes | decodeHit);
  end

  assign wrap = strobes.advance && atMark;

  // Checker state: advances since the register last left the marker state
  logic [CW-1:0] sinceMark;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceMark <= '0;
      armed     <= 1'b0;
    end else if (strobes.advance) begin
      if (atMark) begin
        sinceMark <= CW'(1);
        armed     <= 1'b1;
      end else begin
        sinceMark <= sinceMark + CW'(1);
      end
    end
  end

  // R4: loop length equals the modulus
  p_loop_len_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes.advance && atMark && armed) |-> sinceMark == CW'(MODULUS));

  // R6: the marker never lasts two cycles
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);

  generate
    if (MODULUS == (2 ** WIDTH) - 1) begin : g_skip_chk
      // R8: all-ones is never entered
      p_skip_ones_r8: assert property (@(posedge clk) disable iff (rst)
        state != {WIDTH{1'b1}});
    end
  endgenerate

endmodule

// File: rtl/lfsr_divider.sv
module lfsr_divider
  import lfsr_div_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  output logic [WIDTH-1:0] count,
  output logic             wrap
);

  localparam logic [7:0]       CFG          = chooseConfig(WIDTH, MODULUS);
  localparam bit               CFG_FOUND    = CFG[7];
  localparam bit               USE_DECODE   = CFG[6];
  localparam bit               TOP_IN_AND   = CFG[5];
  localparam logic [WIDTH-1:0] DECODE_STATE = CFG[WIDTH-1:0];
  localparam int               MIN_MOD      = (WIDTH == 4) ? 5 : 2;

  generate
    if ((WIDTH != 4 && WIDTH != 5) || MODULUS < MIN_MOD ||
        MODULUS > (2 ** WIDTH) || !CFG_FOUND) begin : g_bad_cfg
      $error("lfsr_divider: unsupported WIDTH/MODULUS combination");
    end
  endgenerate

  divStrobe_t strobes;

  lfsr_div_ctrl #(
    .WIDTH       (WIDTH),
    .MODULUS     (MODULUS),
    .TOP_IN_AND  (TOP_IN_AND),
    .USE_DECODE  (USE_DECODE),
    .DECODE_STATE(DECODE_STATE)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .state  (count),
    .strobes(strobes),
    .wrap   (wrap)
  );

  lfsr_div_path #(
    .WIDTH(WIDTH)
  ) u_path (
    .clk    (clk),
    .strobes(strobes),
    .state  (count)
  );

endmodule

// File: tb/lfsr_divider_bench.sv
`timescale 1ns/1ps
module lfsr_divider_bench;

  localparam int N4    = 12;   // moduli 5..16
  localparam int N5    = 31;   // moduli 2..32
  localparam int NI    = N4 + N5;
  localparam int STEPS = 100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic enable = 1'b0;

  logic [3:0] c4 [N4];
  logic       w4 [N4];
  logic [4:0] c5 [N5];
  logic       w5 [N5];

  for (genvar i = 0; i < N4; i++) begin : g_w4
    lfsr_divider #(.WIDTH(4), .MODULUS(i + 5)) u_lfsr_divider (
      .clk(clk), .rst(rst), .enable(enable), .count(c4[i]), .wrap(w4[i]));
  end
  for (genvar i = 0; i < N5; i++) begin : g_w5
    lfsr_divider #(.WIDTH(5), .MODULUS(i + 2)) u_lfsr_divider (
      .clk(clk), .rst(rst), .enable(enable), .count(c5[i]), .wrap(w5[i]));
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int hist [NI][STEPS];
  bit wh   [NI][STEPS];

  function automatic int modOf(input int idx);
    return (idx < N4) ? idx + 5 : idx - N4 + 2;
  endfunction
  function automatic int widthOf(input int idx);
    return (idx < N4) ? 4 : 5;
  endfunction
  function automatic int stateOf(input int idx);
    return (idx < N4) ? int'(c4[idx]) : int'(c5[idx - N4]);
  endfunction
  function automatic bit wrapOf(input int idx);
    return (idx < N4) ? w4[idx] : w5[idx - N4];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    for (int idx = 0; idx < NI; idx++) begin
      check(stateOf(idx) == 0, "R1", "count in reset", stateOf(idx), 0);
      check(wrapOf(idx) == 1'b0, "R1", "wrap in reset", int'(wrapOf(idx)), 0);
    end

    // Free-running record
    @(negedge clk);
    rst = 1'b0;
    enable = 1'b1;
    for (int t = 0; t < STEPS; t++) begin
      #1;
      for (int idx = 0; idx < NI; idx++) begin
        hist[idx][t] = stateOf(idx);
        wh[idx][t]   = wrapOf(idx);
      end
      @(negedge clk);
    end

    for (int idx = 0; idx < NI; idx++) begin
      int m;
      int top;
      int mask;
      int t1;
      int t2;
      int mism;
      int dup;
      int bad;
      int ones;
      m = modOf(idx);
      top = 1 << widthOf(idx);
      mask = top - 1;
      t1 = -1;
      t2 = -1;
      for (int t = 0; t < STEPS; t++) if (wh[idx][t] && t1 < 0) t1 = t;
      // R4: entry path bounded
      check(t1 >= 0 && t1 <= top, "R4", "first wrap step", t1, top);
      if (t1 >= 0) begin
        for (int t = t1 + 1; t < STEPS; t++) if (wh[idx][t] && t2 < 0) t2 = t;
        // R4: spacing equals modulus
        check(t2 - t1 == m, "R4", "loop length", t2 - t1, m);
        // R6: wrap only at loop starts
        mism = 0;
        for (int t = 0; t < STEPS; t++)
          if (wh[idx][t] != (t >= t1 && ((t - t1) % m) == 0)) mism++;
        check(mism == 0, "R6", "wrap cycles off pattern", mism, 0);
        // R5: values unique within one loop
        dup = 0;
        for (int a = t1; a < t1 + m; a++)
          for (int b = a + 1; b < t1 + m; b++)
            if (hist[idx][a] == hist[idx][b]) dup++;
        check(dup == 0, "R5", "repeated values in loop", dup, 0);
        // R7: full length passes all-ones
        if (m == top) begin
          ones = 0;
          for (int t = t1; t < t1 + m; t++) if (hist[idx][t] == mask) ones++;
          check(ones == 1, "R7", "all-ones visits per loop", ones, 1);
        end
      end
      // R3: shift relation on every step
      bad = 0;
      for (int t = 0; t < STEPS - 1; t++)
        if ((hist[idx][t + 1] >> 1) != (hist[idx][t] & (mask >> 1))) bad++;
      check(bad == 0, "R3", "steps breaking shift", bad, 0);
      // R8: skip of all-ones
      if (m == top - 1) begin
        ones = 0;
        for (int t = 0; t < STEPS; t++) if (hist[idx][t] == mask) ones++;
        check(ones == 0, "R8", "all-ones visits", ones, 0);
      end
    end

    // R2: enable low freezes the count and silences wrap
    enable = 1'b0;
    #1;
    begin
      int snap [NI];
      for (int idx = 0; idx < NI; idx++) snap[idx] = stateOf(idx);
      for (int r = 0; r < 4; r++) begin
        int moved;
        int pulses;
        @(negedge clk);
        #1;
        moved = 0;
        pulses = 0;
        for (int idx = 0; idx < NI; idx++) begin
          if (stateOf(idx) != snap[idx]) moved++;
          if (wrapOf(idx)) pulses++;
        end
        check(moved == 0, "R2", "instances changed while idle", moved, 0);
        check(pulses == 0, "R2", "wrap while idle", pulses, 0);
      end
    end

    // R1: reset in mid-run
    enable = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    #1;
    begin
      int nz;
      nz = 0;
      for (int idx = 0; idx < NI; idx++) if (stateOf(idx) != 0) nz++;
      check(nz == 0, "R1", "nonzero after mid-run reset", nz, 0);
    end

    // R9: irregular idle cycles do not alter the sequence
    rst = 1'b0;
    begin
      int kk;
      kk = 0;
      for (int c = 0; c < 180; c++) begin
        bit en;
        int off;
        en = ((c % 3) != 1) && ((c % 7) != 5);
        enable = en;
        @(negedge clk);
        #1;
        if (en) kk++;
        if (kk < STEPS) begin
          off = 0;
          for (int idx = 0; idx < NI; idx++) if (stateOf(idx) != hist[idx][kk]) off++;
          check(off == 0, "R9", "instances off sequence", off, 0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule